// File: doc/BRIEF.md
# 64-bit Halt-at-Limit Alarm Timer

A 64-bit up-counter with its own small register file on a 32-bit APB-style bus. Software sets a 64-bit limit as two data words, enables the counter, and picks one of two modes. In halt mode the counter climbs from zero, freezes once it equals the limit, and latches a pending flag. That flag can drive an interrupt line through a mask bit. In free mode the counter ignores the limit and wraps. Committing a new limit restarts the count from zero, and so does switching the enable on. An alarm is therefore "set the limit, wait for the line". Parking the limit at all-ones gives a counter that in practice never stops.

The count keeps moving while software reads it one word at a time. A coherent 64-bit value is read high word, then low word, then high word again, repeating the three reads if the two high words disagree. Every access completes in its access phase, with no wait states.

Top module: `alarm_timer64`

## Requirements
- R1: After reset the control register and the pending flag are 0, the count reads 0, the limit reads all-ones, and `irq` is low.
- R2: The control register sits at offset 0x10. Bit 0 is run, bit 1 is halt mode and bit 2 is the interrupt unmask. Reads return these three bits with zeros above them. Writing 0 stops counting and masks the interrupt.
- R3: While run is set and the counter is not halted, the count rises by exactly one per clock. The count reads at 0x08 (low word) and 0x0C (high word).
- R4: In halt mode, once the count equals the limit, the counter stops and holds the limit value, and the pending flag is set at the next clock. It stays halted until a restart.
- R5: `irq` is high exactly when the pending flag and the unmask bit are both set. The mask never changes the pending flag.
- R6: The pending flag is bit 0 at offset 0x18. Writing a 1 there clears it, and writing a 0 leaves it unchanged.
- R7: A write to 0x00 only stages the low limit word. The 64-bit limit takes effect only when the high word is written at 0x04. Reads of 0x00 and 0x04 return the committed limit.
- R8: Committing a limit resets the count to zero and releases a halt. Counting then continues against the new limit.
- R9: Clearing run freezes the count. A 0-to-1 change of run resets the count to zero. Rewriting run while it is already 1 does not restart the count.
- R10: With halt mode clear, the count runs past the limit and wraps from all-ones to zero without setting the pending flag.
- R11: Offsets 0x14, 0x1C and all other unmapped offsets read as zero, and writes to them change nothing. No access ever waits.
- R12: A high-low-high read with retry returns a count consistent with the moment of the low-word read, even when a carry from the low word into the high word falls inside the read sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while selected for a read |
| irq | output | 1 | Pending flag gated by the unmask bit |

## Verification
The bound checker enforces the following on every clock:
- the one-per-cycle count step;
- the freeze at the limit, and the halted count equalling the committed limit;
- the clear-to-zero after any restart;
- the hold while disabled;
- the stickiness and clearing of the pending flag, and that it stays clear in free mode;
- that the masked line stays low;
- the zero read of unmapped offsets.

Only the bench's scenarios can show the following:
- the stop value across a sweep of limits, including limits that cross the word boundary;
- that a lone low-word write leaves the limit untouched;
- that rewriting run does not restart the count;
- the free-mode wrap;
- the hi-lo-hi retry that catches a carry between the two high reads.

// File: rtl/atimer_pkg.sv
// Shared offsets and control-field layout for the alarm timer.
// Assumes byte addressing with word-aligned registers.
package atimer_pkg;
    localparam int OFF_LIMIT_LO = 'h00;
    localparam int OFF_LIMIT_HI = 'h04;
    localparam int OFF_COUNT_LO = 'h08;
    localparam int OFF_COUNT_HI = 'h0C;
    localparam int OFF_CTRL     = 'h10;
    localparam int OFF_STATUS   = 'h18;

    localparam int CTRL_W = 3;

    // Packed so that run is bit 0, halt_mode is bit 1, unmask is bit 2.
    typedef struct packed {
        logic unmask;
        logic halt_mode;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/atimer_regs.sv
// Register file: decodes bus accesses, stages the low limit word, commits the
// 64-bit limit on a high-word write, holds control and produces restart and
// clear pulses. Assumes zero wait states; reads are combinational.
module atimer_regs
    import atimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              status_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  limit_o,
    output logic              restart_o,
    output logic              clr_o
);
    logic              wr_en;
    logic              sel_lim_lo, sel_lim_hi, sel_cnt_lo, sel_cnt_hi;
    logic              sel_ctrl, sel_stat;
    logic [DATA_W-1:0] stage_lo_q;
    logic [CNT_W-1:0]  limit_q;
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_new;

    assign sel_lim_lo = (paddr == ADDR_W'(OFF_LIMIT_LO));
    assign sel_lim_hi = (paddr == ADDR_W'(OFF_LIMIT_HI));
    assign sel_cnt_lo = (paddr == ADDR_W'(OFF_COUNT_LO));
    assign sel_cnt_hi = (paddr == ADDR_W'(OFF_COUNT_HI));
    assign sel_ctrl   = (paddr == ADDR_W'(OFF_CTRL));
    assign sel_stat   = (paddr == ADDR_W'(OFF_STATUS));

    assign wr_en    = psel & penable & pwrite;
    assign ctrl_new = ctrl_t'(pwdata[CTRL_W-1:0]);

    // Restart on limit commit or on a 0-to-1 change of run.
    assign restart_o = (wr_en & sel_lim_hi)
                     | (wr_en & sel_ctrl & ctrl_new.run & ~ctrl_q.run);
    assign clr_o     = wr_en & sel_stat & pwdata[0];

    assign ctrl_o  = ctrl_q;
    assign limit_o = limit_q;

    // Register updates from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_lo_q <= '1;
            limit_q    <= '1;
            ctrl_q     <= '0;
        end else if (wr_en) begin
            if (sel_lim_lo) stage_lo_q <= pwdata;
            if (sel_lim_hi) limit_q    <= {pwdata, stage_lo_q};
            if (sel_ctrl)   ctrl_q     <= ctrl_new;
        end
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (sel_lim_lo)      prdata = limit_q[DATA_W-1:0];
            else if (sel_lim_hi) prdata = limit_q[CNT_W-1:DATA_W];
            else if (sel_cnt_lo) prdata = count_i[DATA_W-1:0];
            else if (sel_cnt_hi) prdata = count_i[CNT_W-1:DATA_W];
            else if (sel_ctrl)   prdata = DATA_W'(ctrl_q);
            else if (sel_stat)   prdata = DATA_W'(status_i);
        end
    end
endmodule

// File: rtl/atimer_counter.sv
// Up-counter with compare-and-halt. Counts while run is set and not halted.
// In halt mode it freezes on equality with the limit. A restart zeroes it.
// Assumes the limit only changes together with a restart.
module atimer_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             halt_mode_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             halted_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] count_q;
    logic             halted_q;

    assign hit_o    = run_i & halt_mode_i & ~halted_q & ~restart_i
                    & (count_q == limit_i);
    assign count_o  = count_q;
    assign halted_o = halted_q;

    // Count, halt on match, or restart from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            halted_q <= 1'b0;
        end else if (restart_i) begin
            count_q  <= '0;
            halted_q <= 1'b0;
        end else if (run_i && !halted_q) begin
            if (hit_o) halted_q <= 1'b1;
            else       count_q  <= count_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/atimer_irq.sv
// Pending flag and interrupt gate. Set wins over a clear in the same cycle.
module atimer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic unmask_i,
    output logic status_o,
    output logic irq_o
);
    logic status_q;

    // Sticky pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)     status_q <= 1'b0;
        else if (set_i) status_q <= 1'b1;
        else if (clr_i) status_q <= 1'b0;
    end

    assign status_o = status_q;
    assign irq_o    = status_q & unmask_i;
endmodule

// File: rtl/alarm_timer64.sv
// Top of the alarm timer: register file, halt-at-limit counter, interrupt.
// Single clock; bus and counter share clk. No wait states.
module alarm_timer64
    import atimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] limit_w;
    logic [CNT_W-1:0] count_w;
    logic             restart_w, clr_w, hit_w, halted_w, status_w;

    atimer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .count_i(count_w), .status_i(status_w), .ctrl_o(ctrl_w),
        .limit_o(limit_w), .restart_o(restart_w), .clr_o(clr_w)
    );

    atimer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl_w.run),
        .halt_mode_i(ctrl_w.halt_mode), .restart_i(restart_w),
        .limit_i(limit_w), .count_o(count_w), .halted_o(halted_w),
        .hit_o(hit_w)
    );

    atimer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(hit_w), .clr_i(clr_w),
        .unmask_i(ctrl_w.unmask), .status_o(status_w), .irq_o(irq)
    );
endmodule

// File: rtl/atimer_checker.sv
// Cycle-level properties of the alarm timer, bound into alarm_timer64.
module atimer_checker
    import atimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata,
    input logic              irq,
    input logic              run,
    input logic              halt_mode,
    input logic              unmask,
    input logic              restart,
    input logic              clr,
    input logic              hit,
    input logic              halted,
    input logic              status,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  limit
);
    logic mapped;
    assign mapped = (paddr == ADDR_W'(OFF_LIMIT_LO)) || (paddr == ADDR_W'(OFF_LIMIT_HI))
                 || (paddr == ADDR_W'(OFF_COUNT_LO)) || (paddr == ADDR_W'(OFF_COUNT_HI))
                 || (paddr == ADDR_W'(OFF_CTRL))     || (paddr == ADDR_W'(OFF_STATUS));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !halted && !restart && !hit) |=> count == $past(count) + CNT_W'(1));
    a_r4_stop_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (halted && status && count == $past(count)));
    a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !restart) |=> (halted && $stable(count)));
    a_r4_halt_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> count == limit);
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !unmask |-> !irq);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !status);
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0 && !halted));
    a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(count));
    a_r10_free_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_mode && !status) |=> !status);
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && !mapped) |-> prdata == '0);
endmodule

bind alarm_timer64 atimer_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite), .paddr(paddr),
    .prdata(prdata), .irq(irq), .run(ctrl_w.run), .halt_mode(ctrl_w.halt_mode),
    .unmask(ctrl_w.unmask), .restart(restart_w), .clr(clr_w), .hit(hit_w),
    .halted(halted_w), .status(status_w), .count(count_w), .limit(limit_w)
);

// File: tb/tb_alarm_timer64.sv
// Bench on an 8-bit data word (16-bit count) so that word carries and
// wraps are reachable; expected counts come from the bench's own cycle count.
module tb_alarm_timer64;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic          irq;

    int n_run = 0, n_fail = 0;
    int cyc = 0;
    int last_wr = 0;
    int t_r = 0;
    bit done = 0;

    alarm_timer64 #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = AW'(a); pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(posedge clk); #1 last_wr = cyc;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d, output int at);
        @(negedge clk); psel = 1; pwrite = 0; paddr = AW'(a); penable = 0;
        @(negedge clk); penable = 1;
        #1 d = prdata; at = cyc;
        psel = 0; penable = 0;
    endtask

    task automatic readcnt(output logic [15:0] v, output int at, output int retries);
        logic [DW-1:0] h1, h2, lo;
        int x;
        retries = 0;
        for (int k = 0; k < 4; k++) begin
            rd('h0C, h1, x); rd('h08, lo, at); rd('h0C, h2, x);
            if (h1 == h2) break;
            retries++;
        end
        v = {h2, lo};
    endtask

    task automatic prog(input logic [15:0] lim);
        wr('h00, lim[7:0]); wr('h04, lim[15:8]); t_r = last_wr;
    endtask

    task automatic wait_until(input int tgt);
        while (cyc < tgt) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        logic [15:0] v, v2;
        int at, at2, rt, t_d;
        int lims[16] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,255,256,300};

        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd('h10, d, at); chk("R1 ctrl", d, 0);
        rd('h18, d, at); chk("R1 status", d, 0);
        readcnt(v, at, rt); chk("R1 count", v, 0);
        rd('h00, d, at); chk("R1 limit lo", d, 8'hFF);
        rd('h04, d, at); chk("R1 limit hi", d, 8'hFF);
        chk("R1 irq", irq, 0);

        // R2 control readback; R3 counting
        wr('h10, 8'hFF); t_r = last_wr;
        rd('h10, d, at); chk("R2 ctrl readback", d, 8'h07);
        readcnt(v, at, rt); chk("R3 count", v, 16'(at - t_r));
        repeat (7) @(negedge clk);
        readcnt(v, at, rt); chk("R3 count later", v, 16'(at - t_r));

        // R12 coherent read across a low-to-high carry
        prog(16'hFFFF);
        wait_until(t_r + 251);
        readcnt(v, at, rt);
        chk("R12 retry occurred", (rt > 0), 1);
        chk("R12 coherent value", v, 16'(at - t_r));

        // R4/R5 stop-at-limit sweep
        foreach (lims[i]) begin
            wr('h18, 8'h01);
            prog(16'(lims[i]));
            if (lims[i] >= 8) begin
                rd('h18, d, at); chk("R4 flag before limit", d, 0);
            end
            wait_until(t_r + lims[i] + 4);
            readcnt(v, at, rt); chk("R4 stop value", v, 16'(lims[i]));
            rd('h18, d, at); chk("R4 flag set", d, 1);
            chk("R5 irq unmasked", irq, 1);
        end
        repeat (10) @(negedge clk);
        readcnt(v, at, rt); chk("R4 holds at limit", v, 16'd300);

        // R5 mask; R9 rewriting run does not restart
        wr('h10, 8'h03);
        chk("R5 masked irq", irq, 0);
        rd('h18, d, at); chk("R5 flag kept when masked", d, 1);
        wr('h10, 8'h07);
        chk("R5 unmasked irq", irq, 1);
        readcnt(v, at, rt); chk("R9 no restart on rewrite", v, 16'd300);

        // R6 clear semantics
        wr('h18, 8'h00);
        rd('h18, d, at); chk("R6 write 0 keeps flag", d, 1);
        wr('h18, 8'h01);
        rd('h18, d, at); chk("R6 write 1 clears", d, 0);
        chk("R6 irq low", irq, 0);

        // R7 staged low word; R8 commit restarts
        prog(16'd3);
        wait_until(t_r + 8);
        wr('h00, 8'h20);
        repeat (10) @(negedge clk);
        readcnt(v, at, rt); chk("R7 low write alone no restart", v, 16'd3);
        rd('h00, d, at); chk("R7 committed lo unchanged", d, 8'h03);
        wr('h04, 8'h00); t_r = last_wr;
        readcnt(v, at, rt); chk("R8 restart count", v, 16'(at - t_r));
        wait_until(t_r + 'h20 + 4);
        readcnt(v, at, rt); chk("R8 new limit stop", v, 16'h20);
        rd('h00, d, at); chk("R7 committed lo", d, 8'h20);
        rd('h04, d, at); chk("R7 committed hi", d, 8'h00);

        // R9 disable holds, enable edge restarts
        prog(16'hFFFF);
        wait_until(t_r + 30);
        wr('h10, 8'h06); t_d = last_wr;
        repeat (5) @(negedge clk);
        readcnt(v, at, rt); chk("R9 frozen value", v, 16'(t_d - t_r));
        repeat (10) @(negedge clk);
        readcnt(v2, at2, rt); chk("R9 stays frozen", v2, v);
        wr('h10, 8'h07); t_r = last_wr;
        readcnt(v, at, rt); chk("R9 enable edge restarts", v, 16'(at - t_r));

        // R2 writing zero stops and masks
        wr('h10, 8'h00);
        rd('h10, d, at); chk("R2 ctrl cleared", d, 0);
        chk("R2 irq masked", irq, 0);

        // R10 free mode passes limit and wraps
        wr('h18, 8'h01);
        prog(16'd5);
        wr('h10, 8'h05); t_r = last_wr;
        wait_until(t_r + 20);
        readcnt(v, at, rt); chk("R10 passes limit", v, 16'(at - t_r));
        rd('h18, d, at); chk("R10 no flag", d, 0);
        wait_until(t_r + 65536 + 2);
        readcnt(v, at, rt); chk("R10 wrapped", v, 16'((at - t_r) % 65536));
        rd('h18, d, at); chk("R10 no flag after wrap", d, 0);

        // R11 unmapped offsets
        wr('h14, 8'hFF); wr('h1C, 8'hFF);
        rd('h14, d, at); chk("R11 0x14 reads 0", d, 0);
        rd('h1C, d, at); chk("R11 0x1C reads 0", d, 0);
        rd('h10, d, at); chk("R11 ctrl untouched", d, 8'h05);
        rd('h18, d, at); chk("R11 status untouched", d, 0);
        rd('h04, d, at); chk("R11 limit untouched", d, 8'h00);

        finish_run();
    end
endmodule